// File: doc/BRIEF.md
# Banked Pointer Address Generator

This block forms data-memory operand addresses for a small signal processor that has two 256-word RAM banks. It keeps eight 8-bit pointer registers in two groups of four. Pointers 0 to 3 address bank 0 and pointers 4 to 7 address bank 1. The last pointer in each group is fixed at the base of its bank and cannot be changed. Instead of a post-modify code, its 2-bit modifier field names one of the first four words of the bank directly.

The other six pointers can be loaded with an immediate value. After an access they can be left as they are, incremented or decremented, with wrap-around at 256. A request can use single indirection, where the pointer value is the final address. It can also use double indirection. In that case the pointer value is first sent out as a fetch address. The memory returns the word stored there, and the low eight bits of that word become the final address in the same bank. The RAM arrays are outside this block.

Top module: `ptr_agu`

## Requirements
- R1: After reset `out_valid` and `out_l1` are 0, and every pointer reads as 0.
- R2: The bank of every issued address is the pointer index divided by 4: indices 0..3 give bank 0 and indices 4..7 give bank 1.
- R3: A single-indirection request accepted at a clock edge gives `out_valid`=1 in the following cycle. `out_addr` then equals the pointer value held before that edge.
- R4: For pointers 0, 1, 2, 4, 5 and 6, the modifier code sets the update made after the address is issued. Code 0 leaves the pointer unchanged. Codes 1 and 3 add 1, wrapping 255 to 0. Code 2 subtracts 1, wrapping 0 to 255.
- R5: For pointers 3 and 7 the address is the 2-bit modifier value, in the range 0..3. The pointer itself never changes.
- R6: An immediate load (`ld_en`, `ld_ptr`, `ld_val`) to a changeable pointer sets its value. The next access through that pointer uses this value.
- R7: An immediate load aimed at pointer 3 or 7 has no effect.
- R8: A double-indirection request gives, in the next cycle, `out_l1`=1 with the pointer value on `out_addr` and `out_valid`=0. In the cycle after that it gives `out_valid`=1, with `out_addr` equal to the low 8 bits of `l1_data` sampled at that edge, and the same bank.
- R9: A request presented during the cycle in which `out_l1` is 1 is ignored. It produces no output and modifies no pointer.
- R10: When an immediate load and a post-modification target the same pointer at the same edge, the loaded value wins. The issued address is still the value held before that edge.
- R11: `out_valid` and `out_l1` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operand address request |
| req_ptr | input | 3 | Pointer index 0..7 |
| req_mod | input | 2 | Post-modify code, or word offset for the fixed pointers |
| req_dbl | input | 1 | 1 selects double indirection |
| ld_en | input | 1 | Immediate load strobe |
| ld_ptr | input | 3 | Pointer index to load |
| ld_val | input | 8 | Immediate value |
| l1_data | input | 16 | Word read at the first-level address |
| out_valid | output | 1 | Final address valid |
| out_l1 | output | 1 | First-level fetch address on `out_addr` |
| out_addr | output | 8 | Address within the bank |
| out_bank | output | 1 | Bank select |

## Verification
An immediate load and a post-modification can land on the same pointer at the same clock edge. The bench provokes this with directed cases, and random operand requests also carry a random load, so the collision also comes up often by chance. The result is judged by a later read through that pointer, which must show the loaded value, while the access in the colliding cycle must still show the older value. A second overlap comes from a stray request during the wait of a double indirection. It is judged by the missing `out_l1` and by the pointer values read afterwards.

// File: rtl/agu_pkg.sv
// Package: shared modifier encoding for the pointer address generator.
// Assumes: 2-bit modifier field on every operand request.
package agu_pkg;
    typedef enum logic [1:0] {
        MOD_NONE = 2'b00,
        MOD_INC  = 2'b01,
        MOD_DEC  = 2'b10,
        MOD_INC2 = 2'b11
    } mod_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_e;
endpackage

// File: rtl/agu_ptr_file.sv
// Module: agu_ptr_file
// Holds the pointer registers. The last pointer of each bank group is a
// constant zero. The others accept an immediate load or a post-modified
// value, and the load has priority.
// Assumes: at most one load and one modify per cycle.
module agu_ptr_file #(
    parameter int PTR_W         = 8,
    parameter int NUM_PTR       = 8,
    parameter int PTRS_PER_BANK = 4,
    localparam int IDX_W        = $clog2(NUM_PTR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             mod_en,
    input  logic [IDX_W-1:0] mod_idx,
    input  logic [PTR_W-1:0] mod_val,
    output logic [PTR_W-1:0] ptr_q [NUM_PTR]
);
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        if ((i % PTRS_PER_BANK) == PTRS_PER_BANK - 1) begin : g_fixed
            assign ptr_q[i] = '0;
        end else begin : g_var
            logic [PTR_W-1:0] r;
            // Pointer update: the load wins over the post-modify.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= '0;
                else if (ld_en && ld_idx == IDX_W'(i))
                    r <= ld_val;
                else if (mod_en && mod_idx == IDX_W'(i))
                    r <= mod_val;
            end
            assign ptr_q[i] = r;
        end
    end
endmodule

// File: rtl/agu_addr_sel.sv
// Module: agu_addr_sel
// Combinational. For the selected pointer it gives the first-level address,
// the bank, and the post-modified value with its write enable.
// Assumes: the number of pointers per bank is a power of two.
module agu_addr_sel
    import agu_pkg::*;
#(
    parameter int PTR_W         = 8,
    parameter int NUM_PTR       = 8,
    parameter int PTRS_PER_BANK = 4,
    localparam int IDX_W        = $clog2(NUM_PTR),
    localparam int NUM_BANKS    = NUM_PTR / PTRS_PER_BANK,
    localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [PTR_W-1:0]  ptr_q [NUM_PTR],
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        mod,
    output logic [PTR_W-1:0]  first_addr,
    output logic [BANK_W-1:0] bank,
    output logic              mod_chg,
    output logic [PTR_W-1:0]  mod_val
);
    logic             is_fixed;
    logic [PTR_W-1:0] cur;

    assign cur      = ptr_q[idx];
    assign is_fixed = (idx % IDX_W'(PTRS_PER_BANK)) == IDX_W'(PTRS_PER_BANK - 1);
    assign bank     = BANK_W'(idx / IDX_W'(PTRS_PER_BANK));

    // Address: a fixed pointer takes the direct word offset, the others their value.
    always_comb begin
        if (is_fixed)
            first_addr = {{(PTR_W-2){1'b0}}, mod};
        else
            first_addr = cur;
    end

    // Post-modify value: add or subtract one, wrapping at the pointer width.
    always_comb begin
        unique case (mod_e'(mod))
            MOD_INC, MOD_INC2: mod_val = cur + PTR_W'(1);
            MOD_DEC:           mod_val = cur - PTR_W'(1);
            default:           mod_val = cur;
        endcase
        mod_chg = !is_fixed && (mod_e'(mod) != MOD_NONE);
    end
endmodule

// File: rtl/agu_seq.sv
// Module: agu_seq
// Output sequencer. A single-indirection request gives the final address
// one cycle later. A double-indirection request first gives the fetch
// address, then takes the returned word as the final address.
// Assumes: the memory returns the first-level word in the cycle out_l1 is high.
module agu_seq
    import agu_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dbl,
    input  logic [PTR_W-1:0]  first_addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [PTR_W-1:0]  l1_word,
    output logic              issue,
    output logic              out_valid,
    output logic              out_l1,
    output logic [PTR_W-1:0]  out_addr,
    output logic [BANK_W-1:0] out_bank
);
    seq_e state_q;

    // A request is taken only while no second-level fetch is pending.
    assign issue = req_valid && (state_q == SEQ_IDLE);

    // Output registers and the one-bit wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            out_valid <= 1'b0;
            out_l1    <= 1'b0;
            out_addr  <= '0;
            out_bank  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_l1    <= 1'b0;
            if (state_q == SEQ_WAIT) begin
                out_valid <= 1'b1;
                out_addr  <= l1_word;
                state_q   <= SEQ_IDLE;
            end else if (issue) begin
                out_addr <= first_addr;
                out_bank <= bank;
                if (req_dbl) begin
                    out_l1  <= 1'b1;
                    state_q <= SEQ_WAIT;
                end else begin
                    out_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ptr_agu.sv
// Module: ptr_agu (top)
// Banked pointer address generator: eight pointers in two banks, with
// post-modify, direct offsets for the fixed pointers, immediate loads and
// single or double indirection.
// Assumes: the RAM read for the first level returns in the cycle out_l1 is high.
module ptr_agu #(
    parameter int PTR_W         = 8,
    parameter int NUM_PTR       = 8,
    parameter int PTRS_PER_BANK = 4,
    parameter int DATA_W        = 16,
    localparam int IDX_W        = $clog2(NUM_PTR),
    localparam int NUM_BANKS    = NUM_PTR / PTRS_PER_BANK,
    localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_ptr,
    input  logic [1:0]        req_mod,
    input  logic              req_dbl,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_ptr,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic [DATA_W-1:0] l1_data,
    output logic              out_valid,
    output logic              out_l1,
    output logic [PTR_W-1:0]  out_addr,
    output logic [BANK_W-1:0] out_bank
);
    logic [PTR_W-1:0]  ptr_q [NUM_PTR];
    logic [PTR_W-1:0]  first_addr;
    logic [BANK_W-1:0] bank;
    logic              mod_chg;
    logic [PTR_W-1:0]  mod_val;
    logic              issue;
    logic              unused_hi;

    assign unused_hi = ^l1_data[DATA_W-1:PTR_W];

    agu_ptr_file #(
        .PTR_W(PTR_W), .NUM_PTR(NUM_PTR), .PTRS_PER_BANK(PTRS_PER_BANK)
    ) u_file (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_ptr), .ld_val(ld_val),
        .mod_en(issue && mod_chg), .mod_idx(req_ptr), .mod_val(mod_val),
        .ptr_q(ptr_q)
    );

    agu_addr_sel #(
        .PTR_W(PTR_W), .NUM_PTR(NUM_PTR), .PTRS_PER_BANK(PTRS_PER_BANK)
    ) u_sel (
        .ptr_q(ptr_q), .idx(req_ptr), .mod(req_mod),
        .first_addr(first_addr), .bank(bank),
        .mod_chg(mod_chg), .mod_val(mod_val)
    );

    agu_seq #(
        .PTR_W(PTR_W), .BANK_W(BANK_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dbl(req_dbl),
        .first_addr(first_addr), .bank(bank),
        .l1_word(l1_data[PTR_W-1:0]),
        .issue(issue),
        .out_valid(out_valid), .out_l1(out_l1),
        .out_addr(out_addr), .out_bank(out_bank)
    );
endmodule

// File: rtl/agu_chk.sv
// Module: agu_chk
// Property checker for ptr_agu, attached by the bind at the end of this file.
module agu_chk #(
    parameter int PTR_W         = 8,
    parameter int NUM_PTR       = 8,
    parameter int PTRS_PER_BANK = 4,
    parameter int DATA_W        = 16,
    localparam int IDX_W        = $clog2(NUM_PTR),
    localparam int NUM_BANKS    = NUM_PTR / PTRS_PER_BANK,
    localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_ptr,
    input logic [1:0]        req_mod,
    input logic              req_dbl,
    input logic [DATA_W-1:0] l1_data,
    input logic              out_valid,
    input logic              out_l1,
    input logic [PTR_W-1:0]  out_addr,
    input logic [BANK_W-1:0] out_bank
);
    logic unused_chk;
    assign unused_chk = ^l1_data[DATA_W-1:PTR_W];

    // R11
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_l1));

    // R8
    second_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_l1 |=> (out_valid && out_addr == $past(l1_data[PTR_W-1:0])
                    && out_bank == $past(out_bank)));

    // R3
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !out_l1 && !req_dbl) |=>
            (out_valid && out_bank == BANK_W'($past(req_ptr) / IDX_W'(PTRS_PER_BANK))));

    // R5
    fixed_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !out_l1 && !req_dbl
         && (req_ptr % IDX_W'(PTRS_PER_BANK)) == IDX_W'(PTRS_PER_BANK - 1)) |=>
            (out_addr == {{(PTR_W-2){1'b0}}, $past(req_mod)}));

    // R9
    wait_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_l1 |=> !out_l1);
endmodule

bind ptr_agu agu_chk #(
    .PTR_W(PTR_W), .NUM_PTR(NUM_PTR),
    .PTRS_PER_BANK(PTRS_PER_BANK), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_dbl, ld_en;
    logic [2:0]  req_ptr, ld_ptr;
    logic [1:0]  req_mod;
    logic [7:0]  ld_val;
    logic [15:0] l1_data;
    logic        out_valid, out_l1, out_bank;
    logic [7:0]  out_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_ptr [8];

    always #4 clk = ~clk;

    ptr_agu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
        .req_mod(req_mod), .req_dbl(req_dbl), .ld_en(ld_en), .ld_ptr(ld_ptr),
        .ld_val(ld_val), .l1_data(l1_data), .out_valid(out_valid),
        .out_l1(out_l1), .out_addr(out_addr), .out_bank(out_bank)
    );

    function automatic bit is_fixed(int p);
        return (p % 4) == 3;
    endfunction

    function automatic logic [7:0] exp_addr(int p, int m);
        return is_fixed(p) ? 8'(m) : ref_ptr[p];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One operand access with an optional concurrent load; a stray request
    // is driven in the wait cycle of a double indirection.
    task automatic op(int p, int m, bit dbl, bit le, int lp, int lv,
                      logic [15:0] l1w, string tag);
        logic [7:0] ea;
        int eb;
        @(negedge clk);
        req_valid = 1'b1; req_ptr = 3'(p); req_mod = 2'(m); req_dbl = dbl;
        ld_en = le; ld_ptr = 3'(lp); ld_val = 8'(lv);
        ea = exp_addr(p, m);
        eb = p / 4;
        if (!is_fixed(p)) begin
            if (m == 1 || m == 3) ref_ptr[p] = ref_ptr[p] + 8'd1;
            else if (m == 2)      ref_ptr[p] = ref_ptr[p] - 8'd1;
        end
        if (le && !is_fixed(lp)) ref_ptr[lp] = 8'(lv);
        @(negedge clk);
        ld_en = 1'b0;
        if (!dbl) begin
            req_valid = 1'b0;
            chk("R3 valid", 32'(out_valid), 1);
            chk("R11 l1 low", 32'(out_l1), 0);
            chk(tag, 32'(out_addr), 32'(ea));
            chk("R2 bank", 32'(out_bank), 32'(eb));
        end else begin
            l1_data   = l1w;
            req_valid = $urandom_range(0, 1) == 1;
            req_ptr   = 3'($urandom_range(0, 7));
            req_mod   = 2'($urandom_range(0, 3));
            req_dbl   = $urandom_range(0, 1) == 1;
            chk("R8 l1 strobe", 32'(out_l1), 1);
            chk("R8 no valid", 32'(out_valid), 0);
            chk(tag, 32'(out_addr), 32'(ea));
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 valid", 32'(out_valid), 1);
            chk("R9 no new l1", 32'(out_l1), 0);
            chk("R8 final", 32'(out_addr), 32'(l1w[7:0]));
            chk("R2 bank", 32'(out_bank), 32'(eb));
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_ptr = '0; req_mod = '0;
        req_dbl = 1'b0; ld_en = 1'b0; ld_ptr = '0; ld_val = '0; l1_data = '0;
        for (int i = 0; i < 8; i++) ref_ptr[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 l1", 32'(out_l1), 0);
        for (int p = 0; p < 8; p++) op(p, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R1 ptr");

        // Wrap on increment and decrement.
        op(1, 0, 1'b0, 1'b1, 0, 8'hFF, 16'h0, "R6 load");
        op(0, 1, 1'b0, 1'b0, 0, 0, 16'h0, "R4 inc at ff");
        op(0, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R4 wrap to 00");
        op(1, 2, 1'b0, 1'b0, 0, 0, 16'h0, "R4 dec at 00");
        op(1, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R4 wrap to ff");
        op(2, 3, 1'b0, 1'b0, 0, 0, 16'h0, "R4 code 3");
        op(2, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R4 code 3 result");
        // Load and post-modify on the same pointer at the same edge.
        op(5, 1, 1'b0, 1'b1, 5, 8'h40, 16'h0, "R10 old value");
        op(5, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R10 load wins");
        // Loads to fixed pointers and direct offsets.
        op(0, 0, 1'b0, 1'b1, 3, 8'h55, 16'h0, "R7 side");
        op(3, 0, 1'b0, 1'b1, 7, 8'hAA, 16'h0, "R7 ptr3");
        op(7, 2, 1'b0, 1'b0, 0, 0, 16'h0, "R5 ptr7");
        op(3, 3, 1'b0, 1'b0, 0, 0, 16'h0, "R5 ptr3");
        // Double indirection through a changeable and a fixed pointer.
        op(6, 1, 1'b1, 1'b0, 0, 0, 16'hBE37, "R8 first");
        op(6, 0, 1'b0, 1'b0, 0, 0, 16'h0, "R9 ptr after wait");
        op(7, 1, 1'b1, 1'b0, 0, 0, 16'h12C4, "R8 fixed first");

        for (int n = 0; n < 400; n++) begin
            int p;
            int m;
            p = $urandom_range(0, 7);
            m = $urandom_range(0, 3);
            op(p, m, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 7), $urandom_range(0, 255),
               16'($urandom_range(0, 65535)), is_fixed(p) ? "R5 rand" : "R4 rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule